// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers interrupt requests from a set of device lines (sixteen by default) plus one non-maskable line and offers a single interrupt to a processor. Along with the interrupt it gives the number of the request that won. Each numbered line has a pending bit, a disable bit and an in-service bit. When several requests are waiting, a fixed priority picks one: line 0 is the most urgent and the non-maskable line outranks every numbered line. A request is held back while a request of the same or higher rank is still in service, and it is delivered later.

The processor sees one offer at a time. It accepts the offer with a one-cycle take pulse. That pulse moves the request from pending to in service. When the service routine finishes, the processor reports end of service by giving the request number on the end-of-service port. A mask write port loads all disable bits at once.

Top module: `prio_irq_hub`

## Requirements
- R1: After reset, `int_o` is 0, `int_vec_o` is 0, no request is pending or in service, and every mask bit is 1 (all numbered lines disabled).
- R2: The vector given for numbered line i is i. The non-maskable request uses vector NUM_SRC (16 by default).
- R3: Among pending, unmasked numbered requests that are not held back, the lowest line number is offered first.
- R4: A mask bit of 1 stops its line from being offered, but the request stays pending. It is offered once the bit is written to 0. A mask write loads all NUM_SRC bits from `mask_wdata_i` in one cycle.
- R5: A pending non-maskable request is offered whatever the mask holds, and ahead of any pending numbered request.
- R6: A numbered request is held back while any line with the same or a lower number is in service. A lower-numbered line can still be offered while a higher-numbered line is in service, so service can nest.
- R7: An end-of-service pulse clears the in-service bit that matches `eoi_vec_i`. If that number is not in service, the pulse changes nothing.
- R8: Once raised, `int_o` stays high and `int_vec_o` stays unchanged until a cycle with `int_take_i` high. `int_o` is low in the next cycle. `int_take_i` has no effect while `int_o` is low.
- R9: A request line that is high at a clock edge sets its pending bit at that edge. `int_o` rises at the following edge if the request wins. Each accepted request clears its pending bit, so a single pulse is delivered once.
- R10: While the non-maskable request is in service, no numbered line is offered. A second non-maskable request is held until end of service for vector NUM_SRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req_i | input | NUM_SRC | Level request per device line; bit i is line i |
| nmi_req_i | input | 1 | Non-maskable request |
| mask_we_i | input | 1 | Load the mask register this cycle |
| mask_wdata_i | input | NUM_SRC | New mask value; 1 disables the line |
| int_o | output | 1 | Interrupt offered to the processor |
| int_vec_o | output | $clog2(NUM_SRC+1) | Number of the offered request |
| int_take_i | input | 1 | Processor accepts the current offer |
| eoi_valid_i | input | 1 | End-of-service strobe |
| eoi_vec_i | input | $clog2(NUM_SRC+1) | Request number whose service has ended |

## Verification
The bench builds the block with the default of sixteen lines, so the vector is five bits wide and the non-maskable vector is 16. At this size one vector can reach both priority ends and the vector just past the last line. Directed sequences drive nested service, held-back requests that end-of-service pulses release, stray end-of-service numbers, and a non-maskable request arriving while the mask disables everything. A random phase then mixes bursts of requests, mask rewrites, late takes and random end-of-service numbers, and compares the outputs every cycle with a cycle model in the bench.

// File: rtl/pih_pkg.sv
package pih_pkg;

   // Offer stage: idle, or holding an interrupt for the processor.
   typedef enum logic {
      OFR_IDLE = 1'b0,
      OFR_HELD = 1'b1
   } ofr_state_e;

   localparam int PIH_MIN_SRC = 2;
   localparam int PIH_MAX_SRC = 64;

endpackage

// File: rtl/pih_line_bank.sv
// Per-line state: pending latch, disable bit, in-service bit, and the
// readiness of each line after masking and nesting rules.
module pih_line_bank #(
   parameter int NUM_SRC = 16,
   parameter int VEC_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic               mask_we_i,
   input  logic [NUM_SRC-1:0] mask_wdata_i,
   input  logic               take_fire_i,
   input  logic [VEC_W-1:0]   take_vec_i,
   input  logic               eoi_fire_i,
   input  logic [VEC_W-1:0]   eoi_vec_i,
   input  logic               hold_all_i,
   output logic [NUM_SRC-1:0] ready_o
);

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] busy_q;
   logic [NUM_SRC-1:0] busy_upto;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
      logic sel_take;
      logic sel_eoi;

      assign sel_take = take_fire_i && (take_vec_i == VEC_W'(i));
      assign sel_eoi  = eoi_fire_i  && (eoi_vec_i  == VEC_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[i] <= 1'b0;
            mask_q[i] <= 1'b1;
            busy_q[i] <= 1'b0;
         end else begin
            pend_q[i] <= (pend_q[i] | req_i[i]) & ~sel_take;
            if (mask_we_i)
               mask_q[i] <= mask_wdata_i[i];
            if (sel_take)
               busy_q[i] <= 1'b1;
            else if (sel_eoi)
               busy_q[i] <= 1'b0;
         end
      end

      // Any line of equal or higher rank in service blocks this one.
      if (i == 0) begin : g_head
         assign busy_upto[i] = busy_q[i];
      end else begin : g_tail
         assign busy_upto[i] = busy_q[i] | busy_upto[i-1];
      end

      assign ready_o[i] = pend_q[i] & ~mask_q[i] & ~busy_upto[i] & ~hold_all_i;
   end

endmodule

// File: rtl/pih_select.sv
// Fixed-priority pick: the lowest ready index wins.
module pih_select #(
   parameter int NUM_SRC = 16,
   parameter int VEC_W   = 5
) (
   input  logic [NUM_SRC-1:0] ready_i,
   output logic               hit_o,
   output logic [VEC_W-1:0]   idx_o
);

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (ready_i[i]) begin
            hit_o = 1'b1;
            idx_o = VEC_W'(i);
         end
      end
   end

endmodule

// File: rtl/pih_offer.sv
// Holds one offered interrupt and its vector until the processor takes it.
module pih_offer
   import pih_pkg::*;
#(
   parameter int VEC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cand_hit_i,
   input  logic [VEC_W-1:0] cand_vec_i,
   input  logic             take_i,
   output logic             int_o,
   output logic [VEC_W-1:0] vec_o,
   output logic             take_fire_o
);

   ofr_state_e state_q;

   assign int_o       = (state_q == OFR_HELD);
   assign take_fire_o = int_o && take_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= OFR_IDLE;
         vec_o   <= '0;
      end else begin
         case (state_q)
            OFR_IDLE: begin
               if (cand_hit_i) begin
                  state_q <= OFR_HELD;
                  vec_o   <= cand_vec_i;
               end
            end
            default: begin
               if (take_i)
                  state_q <= OFR_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/prio_irq_hub.sv
module prio_irq_hub #(
   parameter  int NUM_SRC = 16,
   localparam int VEC_W   = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req_i,
   input  logic               nmi_req_i,
   input  logic               mask_we_i,
   input  logic [NUM_SRC-1:0] mask_wdata_i,
   output logic               int_o,
   output logic [VEC_W-1:0]   int_vec_o,
   input  logic               int_take_i,
   input  logic               eoi_valid_i,
   input  logic [VEC_W-1:0]   eoi_vec_i
);

   localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

   if (NUM_SRC < pih_pkg::PIH_MIN_SRC || NUM_SRC > pih_pkg::PIH_MAX_SRC) begin : g_bad_size
      $error("prio_irq_hub: NUM_SRC out of supported range");
   end

   logic               take_fire;
   logic               nmi_pend_q;
   logic               nmi_busy_q;
   logic               nmi_ready;
   logic [NUM_SRC-1:0] line_ready;
   logic               line_hit;
   logic [VEC_W-1:0]   line_vec;
   logic               cand_hit;
   logic [VEC_W-1:0]   cand_vec;

   // Non-maskable request: its own pending and in-service bits.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nmi_pend_q <= 1'b0;
         nmi_busy_q <= 1'b0;
      end else begin
         nmi_pend_q <= (nmi_pend_q | nmi_req_i) & ~(take_fire && int_vec_o == NMI_VEC);
         if (take_fire && int_vec_o == NMI_VEC)
            nmi_busy_q <= 1'b1;
         else if (eoi_valid_i && eoi_vec_i == NMI_VEC)
            nmi_busy_q <= 1'b0;
      end
   end

   assign nmi_ready = nmi_pend_q & ~nmi_busy_q;

   pih_line_bank #(
      .NUM_SRC (NUM_SRC),
      .VEC_W   (VEC_W)
   ) u_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (irq_req_i),
      .mask_we_i    (mask_we_i),
      .mask_wdata_i (mask_wdata_i),
      .take_fire_i  (take_fire),
      .take_vec_i   (int_vec_o),
      .eoi_fire_i   (eoi_valid_i),
      .eoi_vec_i    (eoi_vec_i),
      .hold_all_i   (nmi_busy_q),
      .ready_o      (line_ready)
   );

   pih_select #(
      .NUM_SRC (NUM_SRC),
      .VEC_W   (VEC_W)
   ) u_select (
      .ready_i (line_ready),
      .hit_o   (line_hit),
      .idx_o   (line_vec)
   );

   assign cand_hit = nmi_ready | line_hit;
   assign cand_vec = nmi_ready ? NMI_VEC : line_vec;

   pih_offer #(
      .VEC_W (VEC_W)
   ) u_offer (
      .clk         (clk),
      .rst_n       (rst_n),
      .cand_hit_i  (cand_hit),
      .cand_vec_i  (cand_vec),
      .take_i      (int_take_i),
      .int_o       (int_o),
      .vec_o       (int_vec_o),
      .take_fire_o (take_fire)
   );

endmodule

// File: rtl/pih_check.sv
// Port-level checker: keeps its own shadow of mask and service state.
module pih_check #(
   parameter  int NUM_SRC = 16,
   localparam int VEC_W   = $clog2(NUM_SRC + 1),
   localparam int IDX_W   = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               nmi_req_i,
   input logic               mask_we_i,
   input logic [NUM_SRC-1:0] mask_wdata_i,
   input logic               int_o,
   input logic [VEC_W-1:0]   int_vec_o,
   input logic               int_take_i,
   input logic               eoi_valid_i,
   input logic [VEC_W-1:0]   eoi_vec_i
);

   localparam logic [VEC_W-1:0] NMI_VEC = VEC_W'(NUM_SRC);

   logic [NUM_SRC-1:0] sh_mask;
   logic [NUM_SRC-1:0] sh_mask_d;
   logic [NUM_SRC:0]   sh_busy;
   logic [NUM_SRC:0]   sh_busy_d;
   logic               sh_nmip;
   logic               nmi_wait_d;
   logic               taken;
   logic               upto_busy;
   logic [IDX_W-1:0]   idx;

   assign taken = int_o && int_take_i;
   assign idx   = int_vec_o[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_mask    <= '1;
         sh_mask_d  <= '1;
         sh_busy    <= '0;
         sh_busy_d  <= '0;
         sh_nmip    <= 1'b0;
         nmi_wait_d <= 1'b0;
      end else begin
         if (mask_we_i)
            sh_mask <= mask_wdata_i;
         sh_mask_d  <= sh_mask;
         sh_busy_d  <= sh_busy;
         nmi_wait_d <= sh_nmip & ~sh_busy[NUM_SRC];
         sh_nmip    <= (sh_nmip | nmi_req_i) & ~(taken && int_vec_o == NMI_VEC);
         for (int i = 0; i <= NUM_SRC; i++) begin
            if (taken && int_vec_o == VEC_W'(i))
               sh_busy[i] <= 1'b1;
            else if (eoi_valid_i && eoi_vec_i == VEC_W'(i))
               sh_busy[i] <= 1'b0;
         end
      end
   end

   always_comb begin
      upto_busy = sh_busy_d[NUM_SRC];
      for (int i = 0; i < NUM_SRC; i++)
         if (i <= int'(int_vec_o) && sh_busy_d[i])
            upto_busy = 1'b1;
   end

   AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      int_o && !int_take_i |=> int_o && $stable(int_vec_o)); // R8

   AST_TAKE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      int_o && int_take_i |=> !int_o); // R8

   AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> int_vec_o <= NMI_VEC); // R2

   AST_MASK_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_o) && int_vec_o != NMI_VEC |-> !sh_mask_d[idx]); // R4

   AST_NEST_RESPECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_o) && int_vec_o != NMI_VEC |-> !upto_busy); // R6

   AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(int_o) && nmi_wait_d |-> int_vec_o == NMI_VEC); // R5

endmodule

bind prio_irq_hub pih_check #(.NUM_SRC(NUM_SRC)) u_check (
   .clk          (clk),
   .rst_n        (rst_n),
   .nmi_req_i    (nmi_req_i),
   .mask_we_i    (mask_we_i),
   .mask_wdata_i (mask_wdata_i),
   .int_o        (int_o),
   .int_vec_o    (int_vec_o),
   .int_take_i   (int_take_i),
   .eoi_valid_i  (eoi_valid_i),
   .eoi_vec_i    (eoi_vec_i)
);

// File: tb/sim_prio_irq_hub.sv
`timescale 1ns/1ps
module sim_prio_irq_hub;

   localparam int N  = 16;
   localparam int VW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  req = '0;
   logic          nmi = 1'b0;
   logic          we = 1'b0;
   logic [N-1:0]  wdata = '0;
   logic          take = 1'b0;
   logic          eoi_v = 1'b0;
   logic [VW-1:0] eoi_n = '0;
   logic          int_o;
   logic [VW-1:0] vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   prio_irq_hub #(.NUM_SRC(N)) u0 (
      .clk(clk), .rst_n(rst_n), .irq_req_i(req), .nmi_req_i(nmi),
      .mask_we_i(we), .mask_wdata_i(wdata), .int_o(int_o), .int_vec_o(vec),
      .int_take_i(take), .eoi_valid_i(eoi_v), .eoi_vec_i(eoi_n)
   );

   // Cycle model built from the requirements.
   logic [N-1:0]  m_pend, m_mask, m_busy;
   logic          m_nmip, m_nmib, m_int;
   logic [VW-1:0] m_vec;

   function automatic logic [VW:0] pick(input logic [N-1:0] p, m, b, input logic np, nb);
      if (np && !nb) return {1'b1, VW'(N)};
      if (nb) return '0;
      for (int i = 0; i < N; i++) begin
         if (b[i]) return '0;
         if (p[i] && !m[i]) return {1'b1, VW'(i)};
      end
      return '0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pend <= '0; m_mask <= '1; m_busy <= '0;
         m_nmip <= 1'b0; m_nmib <= 1'b0; m_int <= 1'b0; m_vec <= '0;
      end else begin
         logic fire;
         logic [N-1:0] clr;
         logic [VW:0] p;
         fire = m_int && take;
         clr  = (fire && m_vec < VW'(N)) ? (N'(1) << m_vec) : '0;
         m_pend <= (m_pend | req) & ~clr;
         m_nmip <= (m_nmip | nmi) & ~(fire && m_vec == VW'(N));
         if (we) m_mask <= wdata;
         begin
            logic [N-1:0] nb;
            logic nnb;
            nb  = m_busy | clr;
            nnb = m_nmib | (fire && m_vec == VW'(N));
            if (eoi_v && eoi_n < VW'(N) && m_busy[eoi_n[3:0]]) nb[eoi_n[3:0]] = 1'b0;
            if (eoi_v && eoi_n == VW'(N) && m_nmib) nnb = 1'b0;
            m_busy <= nb;
            m_nmib <= nnb;
         end
         p = pick(m_pend, m_mask, m_busy, m_nmip, m_nmib);
         if (m_int) begin
            if (take) m_int <= 1'b0;
         end else if (p[VW]) begin
            m_int <= 1'b1;
            m_vec <= p[VW-1:0];
         end
      end
   end

   // Every-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (int_o !== m_int) begin
            fails++;
            $display("FAIL R8 model int_o actual=%0b expected=%0b t=%0t", int_o, m_int, $time);
         end else if (m_int && vec !== m_vec) begin
            fails++;
            $display("FAIL R3 model vector actual=%0d expected=%0d t=%0t", vec, m_vec, $time);
         end
      end
   end

   task automatic step();
      @(negedge clk);
      req = '0; nmi = 1'b0; we = 1'b0; take = 1'b0; eoi_v = 1'b0;
   endtask

   task automatic steps(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic expect_out(input logic ei, input logic [VW-1:0] ev, input string tag);
      checks++;
      if (int_o !== ei || (ei && vec !== ev)) begin
         fails++;
         $display("FAIL %s actual int=%0b vec=%0d expected int=%0b vec=%0d", tag, int_o, vec, ei, ev);
      end
   endtask

   task automatic end_service(input int n);
      eoi_v = 1'b1; eoi_n = VW'(n); step();
   endtask

   task automatic accept();
      take = 1'b1; step();
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      checks++;
      if (int_o !== 1'b0 || vec !== '0) begin
         fails++;
         $display("FAIL R1 reset actual int=%0b vec=%0d expected int=0 vec=0", int_o, vec);
      end
      // R1/R4: mask starts all ones; request held, not offered.
      req = N'(1) << 3; step(); steps(2);
      expect_out(1'b0, '0, "R1 default mask blocks line 3");
      we = 1'b1; wdata = '0; step();
      expect_out(1'b0, '0, "R4 one cycle after unmask");
      step();
      expect_out(1'b1, 5'd3, "R4 held request offered after unmask, R2 vector is line");
      // R8: higher request arrives while offer held.
      req = N'(1) << 1; step(); steps(2);
      expect_out(1'b1, 5'd3, "R8 vector stable until take");
      accept();
      expect_out(1'b0, '0, "R8 int drops after take");
      step();
      expect_out(1'b1, 5'd1, "R6 higher line nests over line 3");
      accept();
      // R6: lower-ranked requests withheld.
      req = (N'(1) << 5) | (N'(1) << 2); step(); steps(2);
      expect_out(1'b0, '0, "R6 lines 2,5 withheld by line 1");
      end_service(3); steps(2);
      expect_out(1'b0, '0, "R6 still withheld while line 1 in service");
      end_service(1); step();
      expect_out(1'b1, 5'd2, "R3 lowest line wins after release");
      accept();
      end_service(2); step();
      expect_out(1'b1, 5'd5, "R3 next line offered");
      accept();
      end_service(5); steps(2);
      expect_out(1'b0, '0, "R9 each pulse delivered once");
      // R9 latency and R7 stray end of service.
      req = N'(1) << 4; step();
      expect_out(1'b0, '0, "R9 no offer at pending edge");
      step();
      expect_out(1'b1, 5'd4, "R9 offer one edge after pending");
      accept();
      end_service(9);
      req = N'(1) << 6; step(); steps(2);
      expect_out(1'b0, '0, "R7 stray end of service leaves line 4 in service");
      end_service(4); step();
      expect_out(1'b1, 5'd6, "R7 matching end of service releases line 6");
      accept();
      end_service(6);
      // R5/R10: non-maskable path.
      we = 1'b1; wdata = '1; step();
      nmi = 1'b1; step(); step();
      expect_out(1'b1, 5'd16, "R5 non-maskable offered with all lines masked");
      accept();
      we = 1'b1; wdata = '0; step();
      req = N'(1) << 0; step(); steps(2);
      expect_out(1'b0, '0, "R10 line 0 withheld during non-maskable service");
      nmi = 1'b1; step(); step();
      expect_out(1'b0, '0, "R10 second non-maskable withheld");
      end_service(16); step();
      expect_out(1'b1, 5'd16, "R5 non-maskable outranks line 0");
      accept();
      end_service(16); step();
      expect_out(1'b1, 5'd0, "R3 line 0 after non-maskable service");
      accept();
      end_service(0);
      // Random phase, checked every cycle against the model.
      for (int c = 0; c < 4000; c++) begin
         req   = N'($urandom & $urandom & $urandom);
         nmi   = ($urandom % 64) == 0;
         we    = ($urandom % 32) == 0;
         wdata = N'($urandom & $urandom);
         take  = int_o ? ($urandom % 2) == 0 : ($urandom % 4) == 0;
         eoi_v = ($urandom % 3) == 0;
         if ($urandom % 2) begin
            eoi_n = VW'(N);
            for (int i = N - 1; i >= 0; i--) if (m_busy[i]) eoi_n = VW'(i);
            if (m_nmib) eoi_n = VW'(N);
         end else begin
            eoi_n = VW'($urandom % (N + 1));
         end
         @(negedge clk);
      end
      step();
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule